// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address used for each beat of a four-beat burst into a
synchronous memory. When a burst starts it captures the full external address;
from then on the upper bits stay fixed and only the two lowest bits move, always
wrapping inside an aligned group of four.

A burst is started by either of two active-low address strobes: a processor
strobe and a controller strobe. The processor strobe only counts while the
primary chip enable is asserted (low). The controller strobe is not gated by it.
With neither strobe active, the active-low advance input steps to the next beat,
and holding advance high suspends the burst. The mode input picks the beat
order. Low selects a linear count that wraps. High selects an interleaved order,
in which the low bits are the start value XOR a beat index.

The output is taken straight from registers through a small mapping function. It
reflects the decision made at the most recent rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is released and before any strobe, `addr_o` is all zeros.
- R2: A low `cs_n_i` at a rising edge loads `addr_i` into the sequencer, whatever the value of `ce_n_i`. `addr_o` equals that address after the edge, and the beat index restarts at 0.
- R3: A low `ps_n_i` together with a low `ce_n_i` at a rising edge loads `addr_i`, in the same way as R2.
- R4: While `ce_n_i` is high, a low `ps_n_i` is ignored. If `cs_n_i` and `adv_n_i` are both high, `addr_o` is unchanged after the edge.
- R5: With `mode_i` = 0, the low two bits of `addr_o` equal (start + beat) mod 4. For a start of 1 this gives 1,2,3,0.
- R6: With `mode_i` = 1, the low two bits of `addr_o` equal start XOR beat. A start of 2 gives 2,3,0,1 and a start of 3 gives 3,2,1,0.
- R7: Bits above bit 1 of `addr_o` keep their loaded value until the next load.
- R8: With no strobe taking effect and `adv_n_i` high, `addr_o` holds its value.
- R9: When a strobe loads in the same cycle that `adv_n_i` is low, the load wins and beat 0 of the new address is presented.
- R10: With no strobe taking effect and `adv_n_i` low, the beat index advances by one modulo 4. After four advances the start address returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address captured at burst start |
| ps_n_i | input | 1 | Processor address strobe, active low, gated by ce_n_i |
| cs_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench starts bursts at low-bit offsets other than zero in both orders. A
design that mixed up the two orders, or that carried the low-bit sum into bit 2,
would show the wrong beat sequence or a changed upper address. It drives a
processor strobe while chip enable is high, and it drives a strobe and advance
in the same cycle. A missing mask would load a stray address, and reversed
priority would show beat 1 instead of the new start. It also advances four times
in a row and holds advance high across several cycles, which exposes a counter
that does not wrap or that drifts while suspended.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } op_e;
endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic ps_n_i,
  input  logic cs_n_i,
  input  logic adv_n_i,
  input  logic ce_n_i,
  output op_e  op_o
);
  logic ps_qual;

  // processor strobe is masked by an inactive chip enable
  assign ps_qual = !ps_n_i && !ce_n_i;

  always_comb begin
    if (ps_qual || !cs_n_i) op_o = OP_LOAD;
    else if (!adv_n_i)      op_o = OP_STEP;
    else                    op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_addr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  op_e   op_i,
  output beat_t beat_o
);
  beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else begin
      case (op_i)
        OP_LOAD: beat_q <= '0;
        OP_STEP: beat_q <= beat_q + beat_t'(1);
        default: beat_q <= beat_q;
      endcase
    end
  end

  assign beat_o = beat_q;

  a_r2_load_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (beat_o == '0));

  a_r10_step_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP) |=> (beat_o == beat_t'($past(beat_o) + beat_t'(1))));

  a_r8_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(beat_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
(
  input  beat_t  start_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  low_o
);
  beat_t lin_low;
  beat_t xor_low;

  assign lin_low = start_i + beat_i;   // wraps within group of four

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORDER_XOR) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ps_n_i,
  input  logic              cs_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  op_e               op;
  beat_t             beat;
  beat_t             low;
  logic [ADDR_W-1:0] base_q;
  order_e            order;

  assign order = order_e'(mode_i);

  burst_op_decode i_decode (
    .ps_n_i (ps_n_i),
    .cs_n_i (cs_n_i),
    .adv_n_i(adv_n_i),
    .ce_n_i (ce_n_i),
    .op_o   (op)
  );

  burst_beat_cnt i_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .beat_o(beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             base_q <= '0;
    else if (op == OP_LOAD)  base_q <= addr_i;
  end

  burst_order_map i_map (
    .start_i(base_q[BEAT_W-1:0]),
    .beat_i (beat),
    .order_i(order),
    .low_o  (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};

  a_r7_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_n_i || ce_n_i) && cs_n_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  a_r4_ps_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i && cs_n_i && adv_n_i) |=> ($stable(base_q) && $stable(beat)));

  a_r3_ps_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !ps_n_i) |=> (base_q == $past(addr_i)));

  a_r9_load_over_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !adv_n_i) |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W])
                                && beat == '0));

  if (UP_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed beat width");
  end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr_i),
    .ps_n_i (ps_n),
    .cs_n_i (cs_n),
    .adv_n_i(adv_n),
    .ce_n_i (ce_n),
    .mode_i (mode),
    .addr_o (addr_o)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, int beat, logic m);
    logic [1:0] lo;
    if (m) lo = start[1:0] ^ 2'(beat);
    else   lo = 2'(int'(start[1:0]) + beat);
    return {start[AW-1:2], lo};
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one rising edge; inputs change and outputs are sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ps_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic test_reset();
    chk("R1 reset", addr_o, '0);
  endtask

  task automatic test_linear_cs();
    logic [AW-1:0] a = 17'h12345;   // start low bits 01
    mode = 1'b0; ce_n = 1'b1;
    addr_i = a; cs_n = 1'b0; step();
    chk("R2 cs load", addr_o, a);
    for (int i = 1; i < 4; i++) begin
      adv_n = 1'b0; step();
      chk("R5 linear beat", addr_o, expect_addr(a, i, 1'b0));
      chk("R7 upper", {addr_o[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
    end
    adv_n = 1'b0; step();
    chk("R10 wrap", addr_o, a);
  endtask

  task automatic test_xor_ps();
    logic [AW-1:0] a;
    mode = 1'b1; ce_n = 1'b0;
    a = 17'h0ABC6;                  // start 2
    addr_i = a; ps_n = 1'b0; step();
    chk("R3 ps load", addr_o, a);
    for (int i = 1; i < 4; i++) begin
      adv_n = 1'b0; step();
      chk("R6 xor start2", addr_o, expect_addr(a, i, 1'b1));
    end
    a = 17'h1F00F;                  // start 3
    addr_i = a; ps_n = 1'b0; step();
    for (int i = 1; i < 4; i++) begin
      adv_n = 1'b0; step();
      chk("R6 xor start3", addr_o, expect_addr(a, i, 1'b1));
    end
    ce_n = 1'b1;
  endtask

  task automatic test_hold();
    logic [AW-1:0] a = 17'h00401;
    mode = 1'b0;
    addr_i = a; cs_n = 1'b0; step();
    adv_n = 1'b0; step();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R8 suspend", addr_o, expect_addr(a, 1, 1'b0));
    end
  endtask

  task automatic test_mask();
    logic [AW-1:0] a = 17'h0F0F2;
    logic [AW-1:0] b = 17'h15553;
    mode = 1'b0; ce_n = 1'b0;
    addr_i = a; ps_n = 1'b0; step();
    ce_n = 1'b1;
    addr_i = b; ps_n = 1'b0; step();
    chk("R4 ps masked", addr_o, a);
    addr_i = b; cs_n = 1'b0; step();
    chk("R2 cs with ce high", addr_o, b);
  endtask

  task automatic test_priority();
    logic [AW-1:0] a = 17'h03331;
    logic [AW-1:0] b = 17'h1C002;
    mode = 1'b1;
    addr_i = a; cs_n = 1'b0; step();
    adv_n = 1'b0; step();
    addr_i = b; cs_n = 1'b0; adv_n = 1'b0; step();
    chk("R9 load wins", addr_o, b);
    adv_n = 1'b0; step();
    chk("R9 restart beat", addr_o, expect_addr(b, 1, 1'b1));
  endtask

  initial begin : watchdog
    #50us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_linear_cs();
    test_xor_ps();
    test_hold();
    test_mask();
    test_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule